// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Sequencer

This block sits between a synchronous request port and an external asynchronous static RAM that can be organised either as 16-bit words or as 8-bit bytes. A client offers one read or write at a time on a valid/ready handshake. Each request carries an address, write data, two byte-lane enables and a mode bit that picks word or byte organisation. The block then plays out the matching sequence on the memory's chip enables, output enable, write enable, lane strobes, byte-select address line and data-bus drive enable. For a read, it returns the captured data together with a one-cycle completion pulse. A write also ends with a completion pulse.

Each analog interval the memory requires is given as a nanosecond parameter. These intervals are the read access time, the write cycle length, the write pulse width, the write-data setup and the time the memory takes to release the bus. At elaboration each one becomes a whole number of system clocks, rounded up. An elaboration check rejects any interval that would come out as zero cycles. All memory-side outputs come straight from flops, so no glitch reaches the strobes. The address and the byte-select line hold still for the whole time write enable is low. The block drives the data bus only while write enable is low, and it never drives the bus while output enable is low.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is low, and on the first cycle after reset, both chip enables are inactive, output enable and write enable are high, the bus drive enable is low, the completion pulse is low and the request port is ready.
- R2: A request is taken on a clock edge where both valid and ready are high. Ready stays low from that edge until the sequence has finished, and a request held valid while ready is low is not taken.
- R3: A read asserts both chip enables and output enable (low) from the accepting edge for ceil(read-cycle ns / clock ns) cycles (4 with defaults), with write enable high throughout.
- R4: Read data is sampled at the edge that ends the last access cycle and shows on the response data output while the completion pulse is high for exactly one cycle, in the cycle right after the access.
- R5: After a read, chip enables and output enable return inactive and ready stays low for ceil(bus-release ns / clock ns) cycles (2 with defaults), so the bus drive enable cannot be raised within that many cycles of output enable rising.
- R6: A write holds write enable high for one cycle with chip enables active, then holds it low for max(ceil(pulse ns/clock ns), ceil(data-setup ns/clock ns)) cycles (2 with defaults), then high again for max(1, write-cycle cycles minus 1 minus pulse cycles) cycles (1 with defaults) before chip enables drop. The completion pulse is high in the first idle cycle that follows, and ready is high in that same cycle.
- R7: The bus drive enable is high exactly while write enable is low, and it is never high while output enable is low. Write enable and output enable are never low together.
- R8: The memory address and the byte-select line do not change while write enable is low.
- R9: In word mode (mode bit 0) the width output is 1 and the memory address is request address bits [ADDR_W-1:0], so bit ADDR_W is ignored. The byte-select line is 0. The lower lane strobe (bits 7:0) is low when enable bit 0 is set, and the upper lane strobe (bits 15:8) is low when enable bit 1 is set. The write data bus carries the request data unchanged. On a read, any lane whose enable bit is clear returns zero.
- R10: In byte mode (mode bit 1) the width output is 0 and the memory address is request address bits [ADDR_W:1]. The byte-select line carries request address bit 0. The lower lane strobe is low and the upper one is high. On a write, bus bits 7:0 carry request data bits 7:0 and bits 15:8 are zero. On a read, response bits 7:0 come from bus bits 7:0 and bits 15:8 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte organisation, 0 = word organisation |
| req_addr | input | ADDR_W+1 | Byte address in byte mode, word address in bits [ADDR_W-1:0] in word mode |
| req_wdata | input | DATA_W | Write data |
| req_be | input | 2 | Lane enables for word mode (bit 0 lower, bit 1 upper) |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_done after a read |
| sram_addr | output | ADDR_W | Memory word address |
| sram_ba | output | 1 | Byte-select address line for byte organisation |
| sram_wide | output | 1 | Organisation select, 1 = word |
| sram_ce1_n | output | 1 | Active-low chip enable |
| sram_ce2 | output | 1 | Active-high chip enable |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_we_n | output | 1 | Active-low write enable |
| sram_lb_n | output | 1 | Active-low lower lane strobe |
| sram_ub_n | output | 1 | Active-low upper lane strobe |
| sram_dq_out | output | DATA_W | Data toward the memory |
| sram_dq_oe | output | 1 | Drive enable for the data pads |
| sram_dq_in | input | DATA_W | Data from the memory pads |

## Verification
The bench attaches a byte-addressed memory model to the strobes. Disabled lanes in that model return a non-zero filler, so a missing lane mask shows up in the read data. Full-word writes followed by reads prove the basic data path. Single-lane word writes and reads with one enable clear separate correct lane masking from whole-word handling. Byte-mode accesses at odd and even byte addresses, and at the top of the address space, show that the byte-select line and the address shift are right. A word read whose address sets the unused top bit shows that bit is dropped. Requests are kept valid while the block is busy, and one is issued in the write-completion cycle, so the reference model also sees that busy requests are refused and that back-to-back issue is taken at the first legal edge.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_W_SET   = 3'd1,
        ST_W_PULSE = 3'd2,
        ST_W_TAIL  = 3'd3,
        ST_R_ACC   = 3'd4,
        ST_R_TURN  = 3'd5
    } seq_state_e;

    // Whole clocks covering a nanosecond interval, rounded up.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_lanes.sv
module sram_seq_lanes #(
    parameter int DATA_W = 16
) (
    input  logic              byte_mode,
    input  logic [1:0]        be,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rd_bus,
    output logic [DATA_W-1:0] wr_bus,
    output logic [DATA_W-1:0] rd_word,
    output logic              lb_n,
    output logic              ub_n
);

    localparam int LANE_W = DATA_W / 2;

    logic [1:0] lane_en;

    for (genvar l = 0; l < 2; l++) begin : g_lane
        if (l == 0) begin : g_low
            // Lane 0 carries the byte in byte organisation.
            assign lane_en[l] = byte_mode | be[l];
            assign wr_bus[l*LANE_W +: LANE_W] = wdata[l*LANE_W +: LANE_W];
        end else begin : g_high
            assign lane_en[l] = ~byte_mode & be[l];
            assign wr_bus[l*LANE_W +: LANE_W] =
                byte_mode ? '0 : wdata[l*LANE_W +: LANE_W];
        end
        assign rd_word[l*LANE_W +: LANE_W] =
            lane_en[l] ? rd_bus[l*LANE_W +: LANE_W] : '0;
    end

    assign lb_n = ~lane_en[0];
    assign ub_n = ~lane_en[1];

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16,
    parameter int CLK_NS = 20,
    parameter int RC_NS  = 70,
    parameter int WC_NS  = 70,
    parameter int WP_NS  = 35,
    parameter int DW_NS  = 30,
    parameter int HZ_NS  = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_byte,
    input  logic [ADDR_W:0]   req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_be,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ba,
    output logic              sram_wide,
    output logic              sram_ce1_n,
    output logic              sram_ce2,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic              sram_lb_n,
    output logic              sram_ub_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);

    localparam int RD_CYC   = ns_to_cyc(RC_NS, CLK_NS);
    localparam int WP_CYC   = max2(ns_to_cyc(WP_NS, CLK_NS), ns_to_cyc(DW_NS, CLK_NS));
    localparam int WC_CYC   = ns_to_cyc(WC_NS, CLK_NS);
    localparam int TAIL_CYC = max2(1, WC_CYC - 1 - WP_CYC);
    localparam int TA_CYC   = ns_to_cyc(HZ_NS, CLK_NS);
    localparam int MAX_CYC  = max2(max2(RD_CYC, WP_CYC), max2(TAIL_CYC, TA_CYC));
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    if (RD_CYC < 1 || WP_CYC < 1 || WC_CYC < 1 || TA_CYC < 1) begin : g_bad_timing
        $error("sram_seq_ctrl: a timing interval rounds to zero clock cycles");
    end
    if (DATA_W % 2 != 0) begin : g_bad_width
        $error("sram_seq_ctrl: DATA_W must split into two lanes");
    end

    typedef struct packed {
        seq_state_e        state;
        logic              ce;
        logic              oe;
        logic              we;
        logic              dq_oe;
        logic [ADDR_W-1:0] addr;
        logic              ba;
        logic              byte_mode;
        logic [1:0]        be;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } ctl_t;

    ctl_t              ctl_d, ctl_q;
    logic              t_load;
    logic [CNT_W-1:0]  t_val;
    logic              t_last;
    logic [DATA_W-1:0] rd_word;

    sram_seq_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .last     (t_last)
    );

    sram_seq_lanes #(
        .DATA_W (DATA_W)
    ) u_lanes (
        .byte_mode (ctl_q.byte_mode),
        .be        (ctl_q.be),
        .wdata     (ctl_q.wdata),
        .rd_bus    (sram_dq_in),
        .wr_bus    (sram_dq_out),
        .rd_word   (rd_word),
        .lb_n      (sram_lb_n),
        .ub_n      (sram_ub_n)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        t_load     = 1'b0;
        t_val      = '0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.ce        = 1'b1;
                    ctl_d.byte_mode = req_byte;
                    ctl_d.be        = req_be;
                    ctl_d.wdata     = req_wdata;
                    ctl_d.addr      = req_byte ? req_addr[ADDR_W:1] : req_addr[ADDR_W-1:0];
                    ctl_d.ba        = req_byte & req_addr[0];
                    t_load          = 1'b1;
                    if (req_write) begin
                        ctl_d.state = ST_W_SET;
                        t_val       = '0;
                    end else begin
                        ctl_d.state = ST_R_ACC;
                        ctl_d.oe    = 1'b1;
                        t_val       = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            ST_W_SET: begin
                if (t_last) begin
                    ctl_d.state = ST_W_PULSE;
                    ctl_d.we    = 1'b1;
                    ctl_d.dq_oe = 1'b1;
                    t_load      = 1'b1;
                    t_val       = CNT_W'(WP_CYC - 1);
                end
            end
            ST_W_PULSE: begin
                if (t_last) begin
                    // Drive ends on the same edge that ends the pulse.
                    ctl_d.state = ST_W_TAIL;
                    ctl_d.we    = 1'b0;
                    ctl_d.dq_oe = 1'b0;
                    t_load      = 1'b1;
                    t_val       = CNT_W'(TAIL_CYC - 1);
                end
            end
            ST_W_TAIL: begin
                if (t_last) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.ce    = 1'b0;
                    ctl_d.done  = 1'b1;
                end
            end
            ST_R_ACC: begin
                if (t_last) begin
                    ctl_d.state = ST_R_TURN;
                    ctl_d.ce    = 1'b0;
                    ctl_d.oe    = 1'b0;
                    ctl_d.rdata = rd_word;
                    ctl_d.done  = 1'b1;
                    t_load      = 1'b1;
                    t_val       = CNT_W'(TA_CYC - 1);
                end
            end
            ST_R_TURN: begin
                if (t_last) begin
                    ctl_d.state = ST_IDLE;
                end
            end
            default: begin
                ctl_d.state = ST_IDLE;
                ctl_d.ce    = 1'b0;
                ctl_d.oe    = 1'b0;
                ctl_d.we    = 1'b0;
                ctl_d.dq_oe = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready  = (ctl_q.state == ST_IDLE);
    assign rsp_done   = ctl_q.done;
    assign rsp_rdata  = ctl_q.rdata;
    assign sram_addr  = ctl_q.addr;
    assign sram_ba    = ctl_q.ba;
    assign sram_wide  = ~ctl_q.byte_mode;
    assign sram_ce1_n = ~ctl_q.ce;
    assign sram_ce2   = ctl_q.ce;
    assign sram_oe_n  = ~ctl_q.oe;
    assign sram_we_n  = ~ctl_q.we;
    assign sram_dq_oe = ctl_q.dq_oe;

endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk
    import sram_seq_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int CLK_NS = 20,
    parameter int WP_NS  = 35,
    parameter int DW_NS  = 30,
    parameter int HZ_NS  = 30
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_done,
    input logic              sram_ce1_n,
    input logic              sram_ce2,
    input logic              sram_oe_n,
    input logic              sram_we_n,
    input logic              sram_dq_oe,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_ba
);

    localparam int WP_CYC = max2(ns_to_cyc(WP_NS, CLK_NS), ns_to_cyc(DW_NS, CLK_NS));
    localparam int TA_CYC = ns_to_cyc(HZ_NS, CLK_NS);

    int we_lo_cnt;
    int oe_hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_lo_cnt <= 0;
            oe_hi_cnt <= TA_CYC;
        end else begin
            we_lo_cnt <= sram_we_n ? 0 : ((we_lo_cnt < 65535) ? we_lo_cnt + 1 : we_lo_cnt);
            oe_hi_cnt <= !sram_oe_n ? 0 : ((oe_hi_cnt < TA_CYC) ? oe_hi_cnt + 1 : oe_hi_cnt);
        end
    end

    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sram_ce1_n && !sram_ce2 && sram_oe_n && sram_we_n
                          && !sram_dq_oe && !rsp_done && req_ready));

    assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce1_n) |-> !req_ready);

    assert_oe_we_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_oe_n) |-> sram_we_n);

    assert_drive_only_in_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> (sram_oe_n && !sram_we_n));

    assert_pulse_drives_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_n) |-> sram_dq_oe);

    assert_we_inside_ce_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_n) |-> (!sram_ce1_n && sram_ce2));

    assert_pulse_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (we_lo_cnt >= WP_CYC));

    assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_n) |=> (sram_we_n || $stable({sram_addr, sram_ba})));

    assert_turnaround_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> (oe_hi_cnt >= TA_CYC));

    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

endmodule

bind sram_seq_ctrl sram_seq_chk #(
    .ADDR_W (ADDR_W),
    .CLK_NS (CLK_NS),
    .WP_NS  (WP_NS),
    .DW_NS  (DW_NS),
    .HZ_NS  (HZ_NS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_done   (rsp_done),
    .sram_ce1_n (sram_ce1_n),
    .sram_ce2   (sram_ce2),
    .sram_oe_n  (sram_oe_n),
    .sram_we_n  (sram_we_n),
    .sram_dq_oe (sram_dq_oe),
    .sram_addr  (sram_addr),
    .sram_ba    (sram_ba)
);

// File: tb/tb_sram_seq_ctrl.sv
`timescale 1ns/1ps
module tb_sram_seq_ctrl;

    localparam int ADDR_W = 18;
    localparam int DATA_W = 16;
    // Cycle counts from the requirements with a 20 ns clock.
    localparam int RD   = (70 + 19) / 20;
    localparam int WP   = ((35 + 19) / 20 > (30 + 19) / 20) ? (35 + 19) / 20 : (30 + 19) / 20;
    localparam int WCY  = (70 + 19) / 20;
    localparam int TAIL = (WCY - 1 - WP > 1) ? WCY - 1 - WP : 1;
    localparam int TA   = (30 + 19) / 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic              req_byte = 1'b0;
    logic [ADDR_W:0]   req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [1:0]        req_be = '0;
    logic              rsp_done;
    logic [DATA_W-1:0] rsp_rdata;
    logic [ADDR_W-1:0] sram_addr;
    logic              sram_ba, sram_wide, sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n;
    logic              sram_lb_n, sram_ub_n, sram_dq_oe;
    logic [DATA_W-1:0] sram_dq_out;
    logic [DATA_W-1:0] sram_dq_in = '0;

    always #10 clk = ~clk;

    sram_seq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_byte(req_byte), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .rsp_done(rsp_done),
        .rsp_rdata(rsp_rdata), .sram_addr(sram_addr), .sram_ba(sram_ba),
        .sram_wide(sram_wide), .sram_ce1_n(sram_ce1_n), .sram_ce2(sram_ce2),
        .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_lb_n(sram_lb_n),
        .sram_ub_n(sram_ub_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
        .sram_dq_in(sram_dq_in)
    );

    // ---------------- memory model on the strobes ----------------
    logic [7:0] mem [int];
    logic [7:0] shadow [int];

    function automatic logic [7:0] mem_rd(input int k);
        return mem.exists(k) ? mem[k] : 8'h00;
    endfunction

    function automatic logic [7:0] sh_rd(input int k);
        return shadow.exists(k) ? shadow[k] : 8'h00;
    endfunction

    always @(posedge clk) begin
        if (!sram_we_n && !sram_ce1_n && sram_ce2) begin
            if (!sram_wide) begin
                mem[int'({sram_addr, sram_ba})] = sram_dq_oe ? sram_dq_out[7:0] : 8'hEE;
            end else begin
                if (!sram_lb_n) mem[int'({sram_addr, 1'b0})] = sram_dq_oe ? sram_dq_out[7:0]  : 8'hEE;
                if (!sram_ub_n) mem[int'({sram_addr, 1'b1})] = sram_dq_oe ? sram_dq_out[15:8] : 8'hEE;
            end
        end
    end

    always @(negedge clk) begin
        if (!sram_ce1_n && sram_ce2 && !sram_oe_n && sram_we_n) begin
            if (sram_wide)
                sram_dq_in <= {sram_ub_n ? 8'h5A : mem_rd(int'({sram_addr, 1'b1})),
                               sram_lb_n ? 8'h5A : mem_rd(int'({sram_addr, 1'b0}))};
            else
                sram_dq_in <= {8'hA5, mem_rd(int'({sram_addr, sram_ba}))};
        end else begin
            sram_dq_in <= '0;
        end
    end

    // ---------------- reference model ----------------
    typedef struct {
        bit ce, oe, we, dqoe, ready, done, rd;
        logic [ADDR_W-1:0] addr;
        bit ba, wide, lb_n, ub_n;
        logic [15:0] dq;
        logic [15:0] rdata;
        string tg, mt, at;
    } exp_t;

    typedef struct {
        bit wr, byt;
        logic [ADDR_W:0] a;
        logic [15:0] d;
        logic [1:0] be;
        int pre;
    } req_t;

    exp_t eq[$];
    req_t reqs[$];
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    function automatic exp_t idle_e(input string tg);
        exp_t e;
        e = '{default: 0, tg: tg, mt: tg, at: tg};
        e.ready = 1'b1;
        return e;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_entry(input exp_t e);
        chk(e.tg, "ready", 32'(req_ready), 32'(e.ready));
        chk(e.tg, "chip enables", 32'({!sram_ce1_n, sram_ce2}), 32'({e.ce, e.ce}));
        chk(e.tg, "output enable", 32'(!sram_oe_n), 32'(e.oe));
        chk(e.tg, "write enable", 32'(!sram_we_n), 32'(e.we));
        chk(e.tg, "bus drive", 32'(sram_dq_oe), 32'(e.dqoe));
        chk(e.tg, "done", 32'(rsp_done), 32'(e.done));
        if (e.ce) begin
            chk(e.at, "address", 32'(sram_addr), 32'(e.addr));
            chk(e.at, "byte select", 32'(sram_ba), 32'(e.ba));
            chk(e.mt, "width", 32'(sram_wide), 32'(e.wide));
            chk(e.mt, "lower strobe", 32'(sram_lb_n), 32'(e.lb_n));
            chk(e.mt, "upper strobe", 32'(sram_ub_n), 32'(e.ub_n));
        end
        if (e.dqoe) chk(e.mt, "write data", 32'(sram_dq_out), 32'(e.dq));
        if (e.done && e.rd) chk(e.mt, "read data", 32'(rsp_rdata), 32'(e.rdata));
    endtask

    task automatic enqueue(input req_t r);
        exp_t b;
        int wa;
        b = idle_e("R2");
        b.ready = 1'b0;
        b.ce    = 1'b1;
        b.mt    = r.byt ? "R10" : "R9";
        b.at    = b.mt;
        b.wide  = !r.byt;
        b.addr  = r.byt ? r.a[ADDR_W:1] : r.a[ADDR_W-1:0];
        b.ba    = r.byt ? r.a[0] : 1'b0;
        b.lb_n  = r.byt ? 1'b0 : !r.be[0];
        b.ub_n  = r.byt ? 1'b1 : !r.be[1];
        b.dq    = r.byt ? {8'h00, r.d[7:0]} : r.d;
        wa = int'(r.a[ADDR_W-1:0]);
        if (r.wr) begin
            exp_t e;
            if (r.byt) shadow[int'(r.a)] = r.d[7:0];
            else begin
                if (r.be[0]) shadow[2*wa]   = r.d[7:0];
                if (r.be[1]) shadow[2*wa+1] = r.d[15:8];
            end
            e = b; e.tg = "R6"; eq.push_back(e);
            for (int i = 0; i < WP; i++) begin
                e = b; e.tg = "R7"; e.at = "R8"; e.we = 1'b1; e.dqoe = 1'b1; eq.push_back(e);
            end
            for (int i = 0; i < TAIL; i++) begin
                e = b; e.tg = "R6"; eq.push_back(e);
            end
            e = idle_e("R6"); e.done = 1'b1; eq.push_back(e);
        end else begin
            exp_t e;
            logic [15:0] rv;
            if (r.byt) rv = {8'h00, sh_rd(int'(r.a))};
            else rv = {r.be[1] ? sh_rd(2*wa+1) : 8'h00, r.be[0] ? sh_rd(2*wa) : 8'h00};
            for (int i = 0; i < RD; i++) begin
                e = b; e.tg = "R3"; e.oe = 1'b1; eq.push_back(e);
            end
            for (int i = 0; i < TA; i++) begin
                e = idle_e("R5"); e.ready = 1'b0; e.mt = b.mt;
                if (i == 0) begin e.tg = "R4"; e.done = 1'b1; e.rd = 1'b1; e.rdata = rv; end
                eq.push_back(e);
            end
        end
    endtask

    task automatic add(input bit wr, input bit byt, input logic [ADDR_W:0] a,
                       input logic [15:0] d, input logic [1:0] be, input int pre);
        req_t r;
        r.wr = wr; r.byt = byt; r.a = a; r.d = d; r.be = be; r.pre = pre;
        reqs.push_back(r);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        exp_t cur;
        int pre_wait;
        int settle;

        // R9: full word write and read back, then single-lane write and masked reads
        add(1, 0, 19'h00010, 16'h1234, 2'b11, 2);
        add(0, 0, 19'h00010, 16'h0000, 2'b11, 0);
        add(1, 0, 19'h00010, 16'hABCD, 2'b01, 1);
        add(0, 0, 19'h00010, 16'h0000, 2'b11, 0);
        add(0, 0, 19'h00010, 16'h0000, 2'b10, 0);
        // R10: byte write to the upper byte of word 0x10, byte and word read back
        add(1, 1, 19'h00021, 16'hFF77, 2'b00, 0);
        add(0, 1, 19'h00021, 16'h0000, 2'b00, 3);
        add(0, 0, 19'h00010, 16'h0000, 2'b11, 0);
        // R9: top address bit ignored in word mode
        add(0, 0, 19'h40010, 16'h0000, 2'b11, 0);
        // R10: top of the byte space, even byte too
        add(1, 1, 19'h7FFFF, 16'h003C, 2'b00, 0);
        add(1, 1, 19'h7FFFE, 16'h0042, 2'b00, 0);
        add(0, 1, 19'h7FFFF, 16'h0000, 2'b00, 0);
        add(0, 0, 19'h3FFFF, 16'h0000, 2'b11, 0);
        add(1, 0, 19'h00003, 16'h5AA5, 2'b10, 0);
        add(0, 0, 19'h00003, 16'h0000, 2'b11, 0);

        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_entry(idle_e("R1"));
        rst_n = 1'b1;
        cur = idle_e("R1");
        pre_wait = reqs[0].pre;
        settle = 0;
        while (settle < 4) begin
            @(negedge clk);
            check_entry(cur);
            if (pre_wait > 0) begin
                req_valid = 1'b0;
                pre_wait--;
            end else if (reqs.size() > 0) begin
                req_valid = 1'b1;
                req_write = reqs[0].wr;
                req_byte  = reqs[0].byt;
                req_addr  = reqs[0].a;
                req_wdata = reqs[0].d;
                req_be    = reqs[0].be;
                if (cur.ready) begin
                    enqueue(reqs.pop_front());
                    pre_wait = (reqs.size() > 0) ? reqs[0].pre : 0;
                end
            end else begin
                req_valid = 1'b0;
            end
            if (eq.size() > 0) cur = eq.pop_front();
            else cur = idle_e("R2");
            if (reqs.size() == 0 && eq.size() == 0) settle++;
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog: actual=hung expected=complete");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule